// File: doc/BRIEF.md
# PWM Timebase with Period Counters and Event Flags

This block is the timing core of a pulse-width modulator. A main counter advances once per clock while running. When it equals the programmed period value, it returns to a programmable start value. A second, slower counter tracks how many full main periods have elapsed. It has its own start and period values, so it marks a longer frame made of several main periods. The block also compares the main count against a small bank of comparators. Each comparator either signals a match or, when switched to capture mode, records the count on an edge of its own capture input.

All events are collected in a status word whose bits software clears by writing ones. Two independent enable words route the same status bits to a level interrupt and to a level DMA request. An external sync pulse can restart either counter, or both. Configuration goes through a plain write port and a separate combinational read port.

Default sizes are a 16-bit main counter, a 4-bit extended counter and four comparators. The comparator count may be at most eight.

Top module: `pwm_timebase`

## Requirements
- R1: After reset, both counters, the status word, all configuration words and all comparator values read zero, and `irq` and `dma_req` are low.
- R2: While the run bit (control bit 0) is set, the main counter rises by one per clock. In the clock after it equals the period value, it holds the start value. With the run bit clear, it holds its value. A write to the start word (address 1; main start in bits 15:0, extended start in bits 19:16) loads both counters with the written start values on that edge, with priority over everything else.
- R3: The extended counter moves only when the main counter wraps naturally. It rises by one if it differs from its period value and otherwise returns to its start value. The period word (address 2) holds the main period in bits 15:0 and the extended period in bits 19:16.
- R4: Status bit 3 sets in the clock after the running main counter equals the period value. Status bit 2 sets in the clock after the running main counter equals the period value divided by two, rounded down.
- R5: Status bit 1 sets in the clock after a natural main wrap that happens while the extended counter equals its period value.
- R6: With control bit 1 set, a high `sync_in` loads the main counter with its start value and sets status bit 3. With control bit 2 set, it loads the extended counter with its start value and sets status bit 1. A sync that reloads the main counter does not step the extended counter. With a bit clear, `sync_in` has no effect on that counter or its bit.
- R7: A comparator in compare mode sets status bit 4+i in the clock after the running main counter equals its value, held at address 8+i, bits 15:0.
- R8: With capture-mode bit 8+i of the control word set, a rising edge on `cap_in[i]` copies the main count into comparator i and sets status bit 4+i. Compare matches of that comparator are then ignored. A capture wins over a write to the same comparator in the same clock.
- R9: Writing the status word (address 3) clears each bit written as one and leaves bits written as zero. A bit that is being set in the same clock stays set.
- R10: `irq` is high whenever some status bit is set together with the same bit of the interrupt enable word (address 4). `dma_req` is formed the same way from the DMA enable word (address 5).
- R11: A high `fault_in` sets status bit 0 in the next clock, whether or not the counter runs. Address 6 reads the extended count in bits 19:16 and the main count in bits 15:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write word address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 4 | Read word address |
| rd_data | output | 32 | Combinational read data |
| sync_in | input | 1 | External reload request |
| cap_in | input | 4 | Capture inputs, one per comparator |
| fault_in | input | 1 | Fault indication, sets status bit 0 |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA request |

## Verification
The hardest situations to reach are coincidences. Examples are a sync pulse arriving in the very clock the main counter reaches its period while the extended counter is also at its period, a capture edge meeting a write to the same comparator, and a status set meeting a clear of the same bit. Directed steps set up each of these coincidences once. A long random phase then keeps the periods tiny (0 to 15 main, 0 to 3 extended), so wraps, half points and extended wraps recur every few clocks. Against that background, sync pulses, capture toggles, fault pulses and register writes land at random moments and collide often.

// File: rtl/pwmtb_pkg.sv
`timescale 1ns/1ps
package pwmtb_pkg;
  // status bit positions (decoded by software, so fixed)
  localparam int FLAG_FAULT = 0;
  localparam int FLAG_XRLD  = 1;
  localparam int FLAG_HALF  = 2;
  localparam int FLAG_RLD   = 3;
  localparam int FLAG_CMP0  = 4;

  // word addresses
  localparam int A_CTRL   = 0;
  localparam int A_START  = 1;
  localparam int A_PERIOD = 2;
  localparam int A_FLAGS  = 3;
  localparam int A_IRQEN  = 4;
  localparam int A_DMAEN  = 5;
  localparam int A_COUNT  = 6;
  localparam int A_CMP0   = 8;

  // control word bits
  localparam int CTRL_RUN       = 0;
  localparam int CTRL_SYNC_MAIN = 1;
  localparam int CTRL_SYNC_EXT  = 2;
  localparam int CTRL_CAP0      = 8;
endpackage

// File: rtl/pwmtb_counter.sv
`timescale 1ns/1ps
module pwmtb_counter #(
  parameter int CNT_W  = 16,
  parameter int XCNT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              load_now,
  input  logic [CNT_W-1:0]  load_cnt,
  input  logic [XCNT_W-1:0] load_xcnt,
  input  logic [CNT_W-1:0]  start,
  input  logic [XCNT_W-1:0] xstart,
  input  logic [CNT_W-1:0]  period,
  input  logic [XCNT_W-1:0] xperiod,
  input  logic              sync_main,
  input  logic              sync_ext,
  output logic [CNT_W-1:0]  cnt,
  output logic [XCNT_W-1:0] xcnt,
  output logic              evt_rld,
  output logic              evt_half,
  output logic              evt_xrld,
  output logic              evt_wrap
);
  function automatic logic [CNT_W-1:0] half_of(input logic [CNT_W-1:0] p);
    return p >> 1;
  endfunction

  function automatic logic [XCNT_W-1:0] ext_next(input logic [XCNT_W-1:0] cur,
                                                 input logic [XCNT_W-1:0] top,
                                                 input logic [XCNT_W-1:0] base);
    return (cur == top) ? base : cur + 1'b1;
  endfunction

  logic at_period;

  always_comb begin
    at_period = run && (cnt == period);
    evt_wrap  = at_period && !sync_main;
    evt_rld   = at_period || sync_main;
    evt_half  = run && (cnt == half_of(period));
    evt_xrld  = sync_ext || (evt_wrap && (xcnt == xperiod));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      xcnt <= '0;
    end else if (load_now) begin
      cnt  <= load_cnt;
      xcnt <= load_xcnt;
    end else begin
      if (sync_main || evt_wrap) cnt <= start;
      else if (run)              cnt <= cnt + 1'b1;
      if (sync_ext)              xcnt <= xstart;
      else if (evt_wrap)         xcnt <= ext_next(xcnt, xperiod, xstart);
    end
  end
endmodule

// File: rtl/pwmtb_compare.sv
`timescale 1ns/1ps
module pwmtb_compare #(
  parameter int CNT_W   = 16,
  parameter int NUM_CMP = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          run,
  input  logic [CNT_W-1:0]              cnt,
  input  logic [NUM_CMP-1:0]            cap_mode,
  input  logic [NUM_CMP-1:0]            cap_in,
  input  logic [NUM_CMP-1:0]            wr_sel,
  input  logic [CNT_W-1:0]              wr_val,
  output logic [NUM_CMP-1:0][CNT_W-1:0] cmp_val,
  output logic [NUM_CMP-1:0]            cmp_evt
);
  for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
    logic cap_q;
    logic cap_rise;

    always_comb begin
      cap_rise   = cap_in[i] && !cap_q;
      cmp_evt[i] = cap_mode[i] ? cap_rise : (run && (cnt == cmp_val[i]));
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cap_q      <= 1'b0;
        cmp_val[i] <= '0;
      end else begin
        cap_q <= cap_in[i];
        if (cap_mode[i] && cap_rise) cmp_val[i] <= cnt;
        else if (wr_sel[i])          cmp_val[i] <= wr_val;
      end
    end
  end
endmodule

// File: rtl/pwmtb_flags.sv
`timescale 1ns/1ps
module pwmtb_flags #(
  parameter int NF = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] set_vec,
  input  logic [NF-1:0] clr_vec,
  input  logic [NF-1:0] irq_en,
  input  logic [NF-1:0] dma_en,
  output logic [NF-1:0] flags,
  output logic          irq,
  output logic          dma_req
);
  function automatic logic routed(input logic [NF-1:0] f, input logic [NF-1:0] en);
    return |(f & en);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~clr_vec) | set_vec;
  end

  always_comb begin
    irq     = routed(flags, irq_en);
    dma_req = routed(flags, dma_en);
  end
endmodule

// File: rtl/pwm_timebase.sv
`timescale 1ns/1ps
module pwm_timebase
  import pwmtb_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int XCNT_W  = 4,
  parameter int NUM_CMP = 4,
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [DATA_W-1:0]  rd_data,
  input  logic               sync_in,
  input  logic [NUM_CMP-1:0] cap_in,
  input  logic               fault_in,
  output logic               irq,
  output logic               dma_req
);
  localparam int NF = FLAG_CMP0 + NUM_CMP;

  // configuration state
  logic               run_q, sync_main_en_q, sync_ext_en_q;
  logic [NUM_CMP-1:0] cap_mode_q;
  logic [CNT_W-1:0]   start_q, period_q;
  logic [XCNT_W-1:0]  xstart_q, xperiod_q;
  logic [NF-1:0]      irq_en_q, dma_en_q;

  // named internal events
  logic               start_wr, sync_main, sync_ext;
  logic [CNT_W-1:0]   cnt;
  logic [XCNT_W-1:0]  xcnt;
  logic               evt_rld, evt_half, evt_xrld, evt_wrap;
  logic [NUM_CMP-1:0] cmp_evt, cmp_wr_sel;
  logic [NUM_CMP-1:0][CNT_W-1:0] cmp_val;
  logic [NF-1:0]      set_vec, clr_vec, flags;
  logic               unused_wr_bits;

  function automatic logic hit_addr(input logic en, input logic [ADDR_W-1:0] a, input int target);
    return en && (a == ADDR_W'(target));
  endfunction

  assign start_wr       = hit_addr(wr_en, wr_addr, A_START);
  assign sync_main      = sync_in && sync_main_en_q;
  assign sync_ext       = sync_in && sync_ext_en_q;
  assign unused_wr_bits = ^wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q          <= 1'b0;
      sync_main_en_q <= 1'b0;
      sync_ext_en_q  <= 1'b0;
      cap_mode_q     <= '0;
      start_q        <= '0;
      xstart_q       <= '0;
      period_q       <= '0;
      xperiod_q      <= '0;
      irq_en_q       <= '0;
      dma_en_q       <= '0;
    end else begin
      if (hit_addr(wr_en, wr_addr, A_CTRL)) begin
        run_q          <= wr_data[CTRL_RUN];
        sync_main_en_q <= wr_data[CTRL_SYNC_MAIN];
        sync_ext_en_q  <= wr_data[CTRL_SYNC_EXT];
        cap_mode_q     <= wr_data[CTRL_CAP0 +: NUM_CMP];
      end
      if (start_wr) begin
        start_q  <= wr_data[CNT_W-1:0];
        xstart_q <= wr_data[CNT_W +: XCNT_W];
      end
      if (hit_addr(wr_en, wr_addr, A_PERIOD)) begin
        period_q  <= wr_data[CNT_W-1:0];
        xperiod_q <= wr_data[CNT_W +: XCNT_W];
      end
      if (hit_addr(wr_en, wr_addr, A_IRQEN)) irq_en_q <= wr_data[NF-1:0];
      if (hit_addr(wr_en, wr_addr, A_DMAEN)) dma_en_q <= wr_data[NF-1:0];
    end
  end

  for (genvar i = 0; i < NUM_CMP; i++) begin : g_sel
    assign cmp_wr_sel[i] = hit_addr(wr_en, wr_addr, A_CMP0 + i);
  end

  pwmtb_counter #(.CNT_W(CNT_W), .XCNT_W(XCNT_W)) u_counter (
    .clk(clk), .rst_n(rst_n), .run(run_q), .load_now(start_wr),
    .load_cnt(wr_data[CNT_W-1:0]), .load_xcnt(wr_data[CNT_W +: XCNT_W]),
    .start(start_q), .xstart(xstart_q), .period(period_q), .xperiod(xperiod_q),
    .sync_main(sync_main), .sync_ext(sync_ext), .cnt(cnt), .xcnt(xcnt),
    .evt_rld(evt_rld), .evt_half(evt_half), .evt_xrld(evt_xrld), .evt_wrap(evt_wrap)
  );

  pwmtb_compare #(.CNT_W(CNT_W), .NUM_CMP(NUM_CMP)) u_compare (
    .clk(clk), .rst_n(rst_n), .run(run_q), .cnt(cnt), .cap_mode(cap_mode_q),
    .cap_in(cap_in), .wr_sel(cmp_wr_sel), .wr_val(wr_data[CNT_W-1:0]),
    .cmp_val(cmp_val), .cmp_evt(cmp_evt)
  );

  always_comb begin
    set_vec                       = '0;
    set_vec[FLAG_FAULT]           = fault_in;
    set_vec[FLAG_XRLD]            = evt_xrld;
    set_vec[FLAG_HALF]            = evt_half;
    set_vec[FLAG_RLD]             = evt_rld;
    set_vec[FLAG_CMP0 +: NUM_CMP] = cmp_evt;
    clr_vec = hit_addr(wr_en, wr_addr, A_FLAGS) ? wr_data[NF-1:0] : '0;
  end

  pwmtb_flags #(.NF(NF)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec),
    .irq_en(irq_en_q), .dma_en(dma_en_q), .flags(flags), .irq(irq), .dma_req(dma_req)
  );

  always_comb begin
    rd_data = '0;
    case (int'(rd_addr))
      A_CTRL: begin
        rd_data[CTRL_RUN]              = run_q;
        rd_data[CTRL_SYNC_MAIN]        = sync_main_en_q;
        rd_data[CTRL_SYNC_EXT]         = sync_ext_en_q;
        rd_data[CTRL_CAP0 +: NUM_CMP]  = cap_mode_q;
      end
      A_START:  rd_data[CNT_W+XCNT_W-1:0] = {xstart_q, start_q};
      A_PERIOD: rd_data[CNT_W+XCNT_W-1:0] = {xperiod_q, period_q};
      A_FLAGS:  rd_data[NF-1:0]           = flags;
      A_IRQEN:  rd_data[NF-1:0]           = irq_en_q;
      A_DMAEN:  rd_data[NF-1:0]           = dma_en_q;
      A_COUNT:  rd_data[CNT_W+XCNT_W-1:0] = {xcnt, cnt};
      default: begin
        for (int i = 0; i < NUM_CMP; i++)
          if (int'(rd_addr) == A_CMP0 + i) rd_data[CNT_W-1:0] = cmp_val[i];
      end
    endcase
  end
endmodule

// File: rtl/pwmtb_checker.sv
`timescale 1ns/1ps
module pwmtb_checker
  import pwmtb_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int XCNT_W  = 4,
  parameter int NF      = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run,
  input logic              start_wr,
  input logic              sync_main,
  input logic              sync_ext,
  input logic [CNT_W-1:0]  start,
  input logic [CNT_W-1:0]  period,
  input logic [XCNT_W-1:0] xperiod,
  input logic [CNT_W-1:0]  cnt,
  input logic [XCNT_W-1:0] xcnt,
  input logic [NF-1:0]     set_vec,
  input logic [NF-1:0]     clr_vec,
  input logic [NF-1:0]     flags
);
  p_wrap_to_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt == period && !sync_main && !start_wr) |=> (cnt == $past(start)));

  p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt != period && !sync_main && !start_wr) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

  p_hold_stopped_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !sync_main && !start_wr) |=> $stable(cnt));

  p_ext_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt == period && !sync_main && !sync_ext && !start_wr && xcnt != xperiod)
    |=> (xcnt == XCNT_W'($past(xcnt) + 1'b1)));

  p_sync_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_main && !start_wr) |=> (cnt == $past(start)));

  p_reload_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt == period) |=> flags[FLAG_RLD]);

  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((flags & $past(set_vec)) == $past(set_vec)));

  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_vec & ~set_vec) != '0) |=> ((flags & $past(clr_vec & ~set_vec)) == '0));
endmodule

bind pwm_timebase pwmtb_checker #(.CNT_W(CNT_W), .XCNT_W(XCNT_W), .NF(NF)) u_checker (
  .clk(clk), .rst_n(rst_n), .run(run_q), .start_wr(start_wr), .sync_main(sync_main),
  .sync_ext(sync_ext), .start(start_q), .period(period_q), .xperiod(xperiod_q),
  .cnt(cnt), .xcnt(xcnt), .set_vec(set_vec), .clr_vec(clr_vec), .flags(flags)
);

// File: tb/test_pwm_timebase.sv
`timescale 1ns/1ps
module test_pwm_timebase;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        sync_in = 1'b0;
  logic [3:0]  cap_in = '0;
  logic        fault_in = 1'b0;
  logic        irq, dma_req;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pwm_timebase i_pwm_timebase (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .sync_in(sync_in), .cap_in(cap_in),
    .fault_in(fault_in), .irq(irq), .dma_req(dma_req)
  );

  // expected state, built from the requirements
  logic        m_run, m_sm, m_se;
  logic [3:0]  m_capm, m_capq, m_xstart, m_xper, m_xcnt;
  logic [15:0] m_start, m_per, m_cnt;
  logic [7:0]  m_flags, m_ien, m_den;
  logic [15:0] m_cmp [4];

  function automatic logic any_routed(input logic [7:0] f, input logic [7:0] en);
    for (int k = 0; k < 8; k++) if (f[k] && en[k]) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [15:0] half_floor(input logic [15:0] p);
    return 16'(int'(p) / 2);
  endfunction

  task automatic model_step();
    logic [7:0] set = '0;
    logic [7:0] clr = '0;
    logic s_main = sync_in && m_sm;
    logic s_ext  = sync_in && m_se;
    logic at_per = m_run && (m_cnt == m_per);
    logic nat    = at_per && !s_main;
    logic [15:0] n_cnt = m_cnt;
    logic [3:0]  n_xcnt = m_xcnt;
    if (at_per || s_main) set[3] = 1'b1;
    if (m_run && m_cnt == half_floor(m_per)) set[2] = 1'b1;
    if (s_ext || (nat && m_xcnt == m_xper)) set[1] = 1'b1;
    if (fault_in) set[0] = 1'b1;
    for (int i = 0; i < 4; i++) begin
      logic rise = cap_in[i] && !m_capq[i];
      if (m_capm[i]) begin
        if (rise) begin set[4+i] = 1'b1; m_cmp[i] = m_cnt; end
        else if (wr_en && wr_addr == 4'(8+i)) m_cmp[i] = wr_data[15:0];
      end else begin
        if (m_run && m_cnt == m_cmp[i]) set[4+i] = 1'b1;
        if (wr_en && wr_addr == 4'(8+i)) m_cmp[i] = wr_data[15:0];
      end
    end
    m_capq = cap_in;
    if (s_main || nat) n_cnt = m_start;
    else if (m_run)    n_cnt = m_cnt + 16'd1;
    if (s_ext) n_xcnt = m_xstart;
    else if (nat) n_xcnt = (m_xcnt == m_xper) ? m_xstart : m_xcnt + 4'd1;
    if (wr_en && wr_addr == 4'd1) begin n_cnt = wr_data[15:0]; n_xcnt = wr_data[19:16]; end
    if (wr_en && wr_addr == 4'd3) clr = wr_data[7:0];
    m_flags = (m_flags & ~clr) | set;
    m_cnt = n_cnt; m_xcnt = n_xcnt;
    if (wr_en) case (wr_addr)
      4'd0: begin m_run = wr_data[0]; m_sm = wr_data[1]; m_se = wr_data[2]; m_capm = wr_data[11:8]; end
      4'd1: begin m_start = wr_data[15:0]; m_xstart = wr_data[19:16]; end
      4'd2: begin m_per = wr_data[15:0]; m_xper = wr_data[19:16]; end
      4'd4: m_ien = wr_data[7:0];
      4'd5: m_den = wr_data[7:0];
      default: ;
    endcase
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = 0; m_sm = 0; m_se = 0; m_capm = 0; m_capq = 0; m_xstart = 0; m_xper = 0;
      m_xcnt = 0; m_start = 0; m_per = 0; m_cnt = 0; m_flags = 0; m_ien = 0; m_den = 0;
      for (int i = 0; i < 4; i++) m_cmp[i] = 0;
    end else model_step();
  end

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    rd_addr = 4'd3; #1 chk(tag, "status", rd_data, {24'd0, m_flags});
    rd_addr = 4'd6; #1 chk(tag, "counts", rd_data, {12'd0, m_xcnt, m_cnt});
    chk({tag, " R10"}, "irq", {31'd0, irq}, {31'd0, any_routed(m_flags, m_ien)});
    chk({tag, " R10"}, "dma", {31'd0, dma_req}, {31'd0, any_routed(m_flags, m_den)});
    for (int i = 0; i < 4; i++) begin
      rd_addr = 4'(8+i); #1 chk(tag, "comparator", rd_data, {16'd0, m_cmp[i]});
    end
  endtask

  task automatic tick(input string tag);
    @(negedge clk);
    check_all(tag);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input string tag);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick(tag);
    wr_en = 1'b0;
  endtask

  initial begin
    logic [31:0] snap;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state with literal expectations
    for (int a = 0; a < 12; a++) begin
      rd_addr = 4'(a); #1 chk("R1", "reset word", rd_data, 32'd0);
    end
    chk("R1", "irq", {31'd0, irq}, 32'd0);
    chk("R1", "dma", {31'd0, dma_req}, 32'd0);

    // R2 R3 R4 R5: period 9 / ext period 2, start 3 / ext 1
    wr(4'd2, 32'h0002_0009, "R2");
    wr(4'd1, 32'h0001_0003, "R2 start load");
    rd_addr = 4'd6; #1 chk("R2", "start load", rd_data, 32'h0001_0003);
    wr(4'd0, 32'h1, "R2");
    repeat (40) tick("R2 R3 R4 R5");
    wr(4'd0, 32'h0, "R2 stop");
    rd_addr = 4'd6; #1 snap = rd_data;
    repeat (3) tick("R2 stopped");
    rd_addr = 4'd6; #1 chk("R2", "hold while stopped", rd_data, snap);

    // R9: clear all, then set-versus-clear collision on bit 0
    wr(4'd3, 32'hFF, "R9 clear");
    chk("R9", "cleared", {24'd0, m_flags}, 32'd0);
    fault_in = 1'b1;
    wr(4'd3, 32'h01, "R9 set wins");
    fault_in = 1'b0;
    rd_addr = 4'd3; #1 chk("R9", "set wins bit0", {31'd0, rd_data[0]}, 32'd1);
    wr(4'd3, 32'h00, "R9 zero write");
    rd_addr = 4'd3; #1 chk("R9", "zero write keeps", {31'd0, rd_data[0]}, 32'd1);
    wr(4'd3, 32'hFF, "R9 clear");

    // R11: fault while stopped
    fault_in = 1'b1; tick("R11"); fault_in = 1'b0;
    rd_addr = 4'd3; #1 chk("R11", "fault bit", {31'd0, rd_data[0]}, 32'd1);

    // R6: sync with main only, ext only, neither; collide with wrap
    wr(4'd0, 32'h3, "R6 main");
    repeat (4) tick("R6");
    sync_in = 1'b1; tick("R6 main sync"); sync_in = 1'b0;
    wr(4'd0, 32'h5, "R6 ext");
    sync_in = 1'b1; tick("R6 ext sync"); sync_in = 1'b0;
    wr(4'd0, 32'h1, "R6 off");
    rd_addr = 4'd6; #1 snap = rd_data;
    sync_in = 1'b1; tick("R6 disabled"); sync_in = 1'b0;
    rd_addr = 4'd6; #1
    if (snap[15:0] != 16'd9) chk("R6", "sync ignored", {16'd0, rd_data[15:0]}, {16'd0, snap[15:0] + 16'd1});
    wr(4'd0, 32'h7, "R6 both");
    while (m_cnt != m_per) tick("R6 wait");
    sync_in = 1'b1; tick("R6 sync at wrap"); sync_in = 1'b0;

    // R7 R8: compare values, capture mode, capture vs write
    wr(4'd8, 32'd5, "R7");
    wr(4'd9, 32'd7, "R7");
    repeat (12) tick("R7");
    wr(4'd0, 32'h0301, "R8 capture mode");
    cap_in = 4'b0001; tick("R8 capture");
    cap_in = 4'b0011; wr(4'd9, 32'd2, "R8 capture beats write");
    cap_in = 4'b0000; repeat (12) tick("R8 no compare");

    // R10: masks
    wr(4'd4, 32'h08, "R10 irq mask");
    wr(4'd5, 32'h10, "R10 dma mask");
    repeat (12) tick("R10");

    // random phase with tiny periods
    void'($urandom(32'd2024));
    wr(4'd2, 32'h0001_0004, "random setup");
    for (int n = 0; n < 4000; n++) begin
      sync_in  = ($urandom % 16) == 0;
      fault_in = ($urandom % 40) == 0;
      if (($urandom % 6) == 0) cap_in = cap_in ^ 4'($urandom);
      wr_en = ($urandom % 6) == 0;
      wr_addr = 4'($urandom % 12);
      case (wr_addr)
        4'd0:       wr_data = ($urandom & 32'h0F06) | 32'(($urandom % 5) != 0);
        4'd1:       wr_data = {12'd0, 4'($urandom % 4), 16'($urandom % 12)};
        4'd2:       wr_data = {12'd0, 4'($urandom % 4), 16'($urandom % 16)};
        4'd8, 4'd9, 4'd10, 4'd11: wr_data = $urandom % 16;
        default:    wr_data = $urandom;
      endcase
      tick("random R2 R3 R4 R5 R6 R7 R8 R9 R11");
    end
    wr_en = 1'b0; sync_in = 1'b0; fault_in = 1'b0;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule